// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a progressive display: horizontal and vertical sync pulses, horizontal and vertical blanking flags and an active-video flag, all in the pixel clock domain. A pixel counter and a line counter move forward only on cycles where the generation clock enable is high. That lets a downstream video stage set the pace without needing a separate clock.

Each axis is described by five values: the active size, the count at which sync begins, the count at which sync ends (exclusive), the last count of the axis (total minus one), and a polarity bit. Software writes these values into a shadow set. The shadow set is copied into the working set only at the end of a frame, and only when the update enable is high. A frame in progress therefore never shows a mix of old and new timing. At reset the working and shadow sets take their values from parameters; the defaults describe 640x480 at 60 Hz with a 25 MHz pixel clock.

Top module: `vtg_core`

## Requirements
- R1: After synchronous reset both counters are zero and both register sets hold the parameter defaults. The outputs then show the first active pixel: active_video=1, hblank=0, vblank=0, and each sync at its inactive level.
- R2: The pixel counter advances by one only in cycles with gen_ce=1. While gen_ce=0, the counters and all five outputs keep their values.
- R3: The pixel counter wraps to 0 on the enabled cycle after it reaches the horizontal last count. hblank is 1 exactly when the pixel count is at or above the horizontal active size.
- R4: hsync is asserted while the pixel count is in the range [sync start, sync end).
- R5: The line counter advances on each horizontal wrap and itself wraps to 0 after the vertical last count. vblank is 1 exactly when the line count is at or above the vertical active size.
- R6: vsync is asserted for the whole of every line whose line count is in the range [vertical sync start, vertical sync end).
- R7: active_video equals (not hblank) and (not vblank).
- R8: cfg_we=1 writes cfg_wdata into the shadow value picked by cfg_addr: 0 h active, 1 h sync start, 2 h sync end, 3 h last, 4 v active, 5 v sync start, 6 v sync end, 7 v last, 8 polarity (bit 0 horizontal, bit 1 vertical). A shadow write has no effect on the outputs during the current frame.
- R9: On the enabled cycle that wraps both counters (the frame end), the working set is loaded from the shadow set if upd_en=1. The new values take effect from the first pixel of the next frame.
- R10: If upd_en=0 at the frame end, the working set is not loaded, and the next frame uses the old timing.
- R11: Polarity 0 gives active-low sync pulses (the output is 0 inside the sync range and 1 outside it). Polarity 1 gives active-high pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_ce | input | 1 | Generation clock enable; the counters move only when it is high |
| upd_en | input | 1 | Allows the shadow set to be loaded at the frame end |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 4 | Shadow register select |
| cfg_wdata | input | 12 | Shadow register write data |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| active_video | output | 1 | Active picture area flag |

## Verification
The bench builds the block with a miniature raster instead of the 640x480 defaults. Horizontally the parameters are active 8, sync 10 to 12 and last count 15; vertically they are active 4, sync line 5 to 6 and last line 7. One frame is therefore 128 enabled cycles. At this size the bench can walk the line wrap, the frame wrap and every porch edge many times over. It can also cross several frame boundaries, with updates both allowed and refused, so shadow writes, deferred loads and polarity changes are all observed at the outputs within a short run.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    parameter int CW = 12;

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t active;
        cnt_t sync_start;
        cnt_t sync_end;
        cnt_t last;
        logic pol;
    } axis_t;

    typedef struct packed {
        axis_t h;
        axis_t v;
    } timing_t;

    typedef enum logic [3:0] {
        A_H_ACT  = 4'd0,
        A_H_SS   = 4'd1,
        A_H_SE   = 4'd2,
        A_H_LAST = 4'd3,
        A_V_ACT  = 4'd4,
        A_V_SS   = 4'd5,
        A_V_SE   = 4'd6,
        A_V_LAST = 4'd7,
        A_POL    = 4'd8
    } addr_e;

    // Merge one register write into a timing set
    function automatic timing_t apply_write(timing_t t, logic [3:0] a, cnt_t d);
        timing_t r;
        r = t;
        case (a)
            A_H_ACT:  r.h.active     = d;
            A_H_SS:   r.h.sync_start = d;
            A_H_SE:   r.h.sync_end   = d;
            A_H_LAST: r.h.last       = d;
            A_V_ACT:  r.v.active     = d;
            A_V_SS:   r.v.sync_start = d;
            A_V_SE:   r.v.sync_end   = d;
            A_V_LAST: r.v.last       = d;
            A_POL: begin
                r.h.pol = d[0];
                r.v.pol = d[1];
            end
            default: r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter timing_t RST_VAL = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  cnt_t       wr_data,
    input  logic       load,
    output timing_t    work
);

    timing_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RST_VAL;
            work   <= RST_VAL;
        end else begin
            if (wr_en) begin
                shadow <= apply_write(shadow, wr_addr, wr_data);
            end
            if (load) begin
                work <= shadow;
            end
        end
    end

endmodule

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  cnt_t last,
    output cnt_t cnt,
    output logic wrap
);

    assign wrap = step && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + cnt_t'(1);
        end
    end

endmodule

// File: rtl/vtg_axis_decode.sv
module vtg_axis_decode
    import vtg_pkg::*;
(
    input  cnt_t  cnt,
    input  axis_t cfg,
    output logic  blank,
    output logic  sync
);

    logic in_pulse;

    always_comb begin
        blank    = (cnt >= cfg.active);
        in_pulse = (cnt >= cfg.sync_start) && (cnt < cfg.sync_end);
        sync     = cfg.pol ? in_pulse : ~in_pulse;
    end

endmodule

// File: rtl/vtg_core.sv
module vtg_core
    import vtg_pkg::*;
#(
    parameter int H_ACTIVE     = 640,
    parameter int H_SYNC_START = 656,
    parameter int H_SYNC_END   = 752,
    parameter int H_LAST       = 799,
    parameter bit H_POL        = 1'b0,
    parameter int V_ACTIVE     = 480,
    parameter int V_SYNC_START = 490,
    parameter int V_SYNC_END   = 492,
    parameter int V_LAST       = 524,
    parameter bit V_POL        = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gen_ce,
    input  logic          upd_en,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    output logic          hsync,
    output logic          vsync,
    output logic          hblank,
    output logic          vblank,
    output logic          active_video
);

    localparam timing_t DEFAULTS = '{
        h: '{active: cnt_t'(H_ACTIVE), sync_start: cnt_t'(H_SYNC_START),
             sync_end: cnt_t'(H_SYNC_END), last: cnt_t'(H_LAST), pol: H_POL},
        v: '{active: cnt_t'(V_ACTIVE), sync_start: cnt_t'(V_SYNC_START),
             sync_end: cnt_t'(V_SYNC_END), last: cnt_t'(V_LAST), pol: V_POL}
    };

    timing_t work;
    cnt_t    h_cnt;
    cnt_t    v_cnt;
    logic    h_wrap;
    logic    v_wrap;

    vtg_regs #(.RST_VAL(DEFAULTS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .load    (v_wrap && upd_en),
        .work    (work)
    );

    vtg_axis_counter u_hcnt (
        .clk  (clk),
        .rst  (rst),
        .step (gen_ce),
        .last (work.h.last),
        .cnt  (h_cnt),
        .wrap (h_wrap)
    );

    vtg_axis_counter u_vcnt (
        .clk  (clk),
        .rst  (rst),
        .step (h_wrap),
        .last (work.v.last),
        .cnt  (v_cnt),
        .wrap (v_wrap)
    );

    vtg_axis_decode u_hdec (
        .cnt   (h_cnt),
        .cfg   (work.h),
        .blank (hblank),
        .sync  (hsync)
    );

    vtg_axis_decode u_vdec (
        .cnt   (v_cnt),
        .cfg   (work.v),
        .blank (vblank),
        .sync  (vsync)
    );

    assign active_video = ~hblank & ~vblank;

endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk
    import vtg_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    gen_ce,
    input logic    hsync,
    input logic    vsync,
    input logic    hblank,
    input logic    vblank,
    input logic    active_video,
    input cnt_t    h_cnt,
    input cnt_t    v_cnt,
    input timing_t work
);

    logic line_end;
    logic frame_end;

    assign line_end  = gen_ce && (h_cnt >= work.h.last);
    assign frame_end = line_end && (v_cnt >= work.v.last);

    p_hstep_r2: assert property (@(posedge clk) disable iff (rst)
        (gen_ce && (h_cnt < work.h.last)) |=> (h_cnt == $past(h_cnt) + cnt_t'(1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !gen_ce |=> ($stable(h_cnt) && $stable(v_cnt)
                     && $stable({hsync, vsync, hblank, vblank, active_video})));

    p_hwrap_r3: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (h_cnt == '0));

    p_vhold_r5: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(v_cnt));

    p_vwrap_r5: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (v_cnt == '0));

    p_active_r7: assert property (@(posedge clk) disable iff (rst)
        active_video == (!hblank && !vblank));

    p_shadow_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(work));

endmodule

bind vtg_core vtg_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .gen_ce       (gen_ce),
    .hsync        (hsync),
    .vsync        (vsync),
    .hblank       (hblank),
    .vblank       (vblank),
    .active_video (active_video),
    .h_cnt        (h_cnt),
    .v_cnt        (v_cnt),
    .work         (work)
);

// File: tb/vtg_core_bench.sv
module vtg_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_ce = 1'b0;
    logic        upd_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        hsync, vsync, hblank, vblank, active_video;

    int errors = 0;
    int checks = 0;
    int pos = 0;

    always #5 clk = ~clk;

    vtg_core #(
        .H_ACTIVE(8), .H_SYNC_START(10), .H_SYNC_END(12), .H_LAST(15), .H_POL(1'b0),
        .V_ACTIVE(4), .V_SYNC_START(5),  .V_SYNC_END(6),  .V_LAST(7),  .V_POL(1'b0)
    ) u_vtg_core (
        .clk(clk), .rst(rst), .gen_ce(gen_ce), .upd_en(upd_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .active_video(active_video)
    );

    // Raster with 16 pixels per line, 8 lines per frame
    // Expected bits: {hsync, hblank, vsync, vblank, active_video}
    typedef struct packed {
        logic [15:0] at;
        logic [4:0]  exp;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{16'd7,   5'b10101},
        '{16'd8,   5'b11100},
        '{16'd10,  5'b01100},
        '{16'd11,  5'b01100},
        '{16'd12,  5'b11100},
        '{16'd15,  5'b11100},
        '{16'd16,  5'b10101},
        '{16'd64,  5'b10110},
        '{16'd80,  5'b10010},
        '{16'd96,  5'b10110},
        '{16'd127, 5'b11110},
        '{16'd128, 5'b10101}
    };

    function automatic logic [4:0] outs();
        return {hsync, hblank, vsync, vblank, active_video};
    endfunction

    task automatic check(string req, logic [4:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s at pos %0d: actual=%b expected=%b", req, pos, outs(), exp);
        end
    endtask

    task automatic step_to(int target);
        while (pos < target) begin
            gen_ce = 1'b1;
            @(negedge clk);
            pos++;
        end
        gen_ce = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [11:0] d);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 5'b10101);

        // Table walk: R3 R4 R5 R6 R7 with default polarity (R11, active-low)
        for (int i = 0; i < 12; i++) begin
            step_to(int'(VECS[i].at));
            check("R3/R4/R5/R6/R7 table", VECS[i].exp);
        end

        // R2: enable low freezes the raster
        step_to(137);
        check("R2 before hold", 5'b11100);
        idle(5);
        check("R2 hold", 5'b11100);
        step_to(138);
        check("R2 one step", 5'b01100);

        // R8 and R9: shadow writes, applied at frame end
        upd_en = 1'b1;
        wr(4'd1, 12'd2);
        wr(4'd2, 12'd4);
        step_to(147);
        check("R8 no effect mid-frame", 5'b10101);
        step_to(259);
        check("R9 new sync start", 5'b00101);
        step_to(266);
        check("R9 old sync gone", 5'b11100);

        // R10: no load when update enable is low
        upd_en = 1'b0;
        wr(4'd0, 12'd4);
        step_to(389);
        check("R10 refused load", 5'b10101);
        upd_en = 1'b1;
        step_to(517);
        check("R10 later load", 5'b11100);

        // R11: active-high polarity on both axes
        wr(4'd8, 12'd3);
        step_to(642);
        check("R11 hsync high", 5'b10001);
        step_to(645);
        check("R11 hsync released", 5'b01000);
        step_to(720);
        check("R11 vsync high", 5'b00110);

        // R1: reset mid-run restores defaults
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pos = 0;
        check("R1 reset again", 5'b10101);
        step_to(5);
        check("R1 defaults restored", 5'b10101);
        step_to(10);
        check("R1 default sync", 5'b01100);

        finish_run();
    end

endmodule